// File: doc/BRIEF.md
# Descriptor Lane Packer with Descriptor FIFO

This block sits behind a 32-bit configuration port. Software builds 128-bit descriptor words by writing four 32-bit lanes, each at its own word address. The lane window starts at `0x178`, and the lanes may be written in any order. The block holds the lanes in a staging register and keeps a lane-written mask. The write that fills the last missing lane pushes the merged 128-bit word into a FIFO and empties the mask at the same edge.

A descriptor is either one word (short) or two words (long). Bit 127 of the first word of a descriptor is its header flag: 1 means long. Software must write the header word of a long descriptor first. The consumer side is a ready/valid port that presents a descriptor only when all of its words are stored. It hands the header word out first.

Two states govern the consumer port:
- `EG_HEAD`: the head entry is the start of a descriptor. The port is valid when that entry is short, or when it is long and a second entry is also stored. Taking a long header moves the port to `EG_TAIL`. Taking a short word keeps it in `EG_HEAD`.
- `EG_TAIL`: the second word of a long descriptor is presented. Taking it returns the port to `EG_HEAD`.

Software reads the FIFO fill level at offset `0x5C`. A sticky overflow flag reports a completing write that found the FIFO full. A soft clear input empties everything.

Top module: `lane_pack_fifo`

## Requirements
- R1: After `rst_n` is low, the level reads 0, `dsc_valid` is 0 and `ovf_flag` is 0.
- R2: Lane i sits at address `0x178 + 4*i` and fills bits `[32*i+31:32*i]` of the word. The word is pushed only by the write that completes all four lanes, in whatever order they came. Three distinct lanes leave the level unchanged.
- R3: Writing a lane that is already written before the word completes replaces its value. It adds no lane to the mask, and the later value is the one pushed.
- R4: A read at `rd_addr == 0x5C` returns the FIFO entry count in bits 7:0 and zero above. A read at any other address returns 0. The count updates at the edge of each push or pop.
- R5: A completing write that meets a full FIFO is discarded. It sets `ovf_flag`, which stays set until a soft clear. The three lanes already written are kept, so rewriting the missing lane after a pop pushes the word.
- R6: A head word with bit 127 at 0 is a short descriptor. It is presented with `dsc_last` = 1 as soon as it is stored.
- R7: A head word with bit 127 at 1 is withheld while it is the only entry. Once its second word is stored, the header is presented with `dsc_last` = 0 and then the second word with `dsc_last` = 1. Bit 127 of the second word is not interpreted.
- R8: A word leaves only on a cycle with both `dsc_valid` and `dsc_ready` high. While `dsc_ready` is low, `dsc_valid` and `dsc_data` hold.
- R9: A cycle with `soft_clr` high empties the lane mask and the FIFO, zeroes the level, clears `ovf_flag` and returns the port to `EG_HEAD`.
- R10: A write outside the four lane addresses, or a write not aligned to a 4-byte word, changes no lane and no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of the mask, the FIFO, the level, the flag and the port state |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Read data (level at `0x5C`, otherwise 0) |
| ovf_flag | output | 1 | Sticky flag for a dropped completing write |
| dsc_valid | output | 1 | A descriptor word is offered |
| dsc_ready | input | 1 | The consumer takes the offered word |
| dsc_data | output | 128 | Offered descriptor word |
| dsc_last | output | 1 | The offered word ends its descriptor |

## Verification
The bench writes four lanes in all 24 orders and checks that only the fourth write raises the level. A design that pushed early, or that placed a lane by arrival order, would show a level change after three writes or a misplaced lane. It fills the FIFO to depth and drops a completing write, then retries with only the missing lane. A design that cleared or kept the wrong lanes would push a corrupted word or none. A long header is held alone in the FIFO to catch a port that offers half a descriptor. Its second word carries bit 127 set, to catch a port that reads a header in the tail. Rewritten lanes, stray or misaligned addresses, and a soft clear with a partial mask each target a mask that counts writes rather than lanes.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;
    typedef enum logic {
        EG_HEAD = 1'b0,
        EG_TAIL = 1'b1
    } eg_state_t;
endpackage

// File: rtl/lane_gather.sv
module lane_gather #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE = 12'h178
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_clr,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic                      fifo_full,
    output logic                      push,
    output logic [WORD_W*LANES-1:0]   push_word,
    output logic                      ovf
);
    localparam int STEP    = WORD_W / 8;
    localparam int ALIGN   = $clog2(STEP);
    localparam int LANE_IW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [ADDR_W-1:0]  ofs;
    logic [LANE_IW-1:0] lane_sel;
    logic [LANES-1:0]   lane_bit;
    logic [LANES-1:0]   mask;
    logic [WORD_W-1:0]  lanes [LANES];
    logic               hit, complete, drop;

    assign ofs      = wr_addr - BASE;
    assign hit      = wr_en && (wr_addr >= BASE) && (ofs < ADDR_W'(LANES * STEP))
                      && (ofs[ALIGN-1:0] == '0);
    assign lane_sel = ofs[ALIGN +: LANE_IW];
    assign lane_bit = hit ? (LANES'(1) << lane_sel) : '0;
    assign complete = hit && ((mask | lane_bit) == '1);
    assign push     = complete && !fifo_full;
    assign drop     = complete && fifo_full;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign push_word[gi*WORD_W +: WORD_W] = lane_bit[gi] ? wr_data : lanes[gi];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lanes[gi] <= '0;
            else if (lane_bit[gi] && !drop)
                lanes[gi] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
            ovf  <= 1'b0;
        end else if (soft_clr) begin
            mask <= '0;
            ovf  <= 1'b0;
        end else begin
            if (push)
                mask <= '0;
            else if (hit && !drop)
                mask <= mask | lane_bit;
            if (drop)
                ovf <= 1'b1;
        end
    end

    assert_push_clears_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> mask == '0);
    assert_no_push_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full);
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !soft_clr) |=> ovf);
    assert_drop_keeps_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !soft_clr) |=> $stable(mask));
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_word,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head = mem[rptr];
    assign full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (push)
            mem[wptr] <= push_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (soft_clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/dsc_egress.sv
module dsc_egress
    import lane_pack_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int CNT_W    = 4,
    parameter int LONG_BIT = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic [DATA_W-1:0] head,
    input  logic [CNT_W-1:0]  count,
    input  logic              ready,
    output logic              valid,
    output logic              last,
    output logic [DATA_W-1:0] data,
    output logic              pop
);
    eg_state_t state, state_nxt;
    logic      head_long;

    assign head_long = head[LONG_BIT];
    assign data      = head;
    assign pop       = valid && ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= EG_HEAD;
        else if (soft_clr)
            state <= EG_HEAD;
        else
            state <= state_nxt;
    end

    always_comb begin
        valid     = 1'b0;
        last      = 1'b0;
        state_nxt = state;
        unique case (state)
            EG_HEAD: begin
                valid = (count != '0) && (!head_long || count >= CNT_W'(2));
                last  = !head_long;
                if (valid && ready && head_long)
                    state_nxt = EG_TAIL;
            end
            EG_TAIL: begin
                valid = (count != '0);
                last  = 1'b1;
                if (valid && ready)
                    state_nxt = EG_HEAD;
            end
        endcase
    end

    assert_tail_has_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == EG_TAIL |-> count != '0);
    assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && !soft_clr) |=> (valid && $stable(data)));
endmodule

// File: rtl/lane_pack_fifo.sv
module lane_pack_fifo #(
    parameter int WORD_W   = 32,
    parameter int LANES    = 4,
    parameter int DEPTH    = 8,
    parameter int ADDR_W   = 12,
    parameter int LVL_W    = 8,
    parameter logic [ADDR_W-1:0] LANE_BASE = 12'h178,
    parameter logic [ADDR_W-1:0] LEVEL_OFS = 12'h05C,
    parameter int LONG_BIT = WORD_W * LANES - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    soft_clr,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    ovf_flag,
    output logic                    dsc_valid,
    input  logic                    dsc_ready,
    output logic [WORD_W*LANES-1:0] dsc_data,
    output logic                    dsc_last
);
    localparam int DATA_W = WORD_W * LANES;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              push, pop, full;
    logic [DATA_W-1:0] push_word, head;
    logic [CNT_W-1:0]  count;
    logic [LVL_W-1:0]  level;

    lane_gather #(.WORD_W(WORD_W), .LANES(LANES), .ADDR_W(ADDR_W), .BASE(LANE_BASE)) gather_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fifo_full(full), .push(push), .push_word(push_word), .ovf(ovf_flag)
    );

    word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .push(push), .push_word(push_word), .pop(pop),
        .head(head), .count(count), .full(full)
    );

    dsc_egress #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LONG_BIT(LONG_BIT)) egress_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .head(head), .count(count), .ready(dsc_ready),
        .valid(dsc_valid), .last(dsc_last), .data(dsc_data), .pop(pop)
    );

    assign level   = LVL_W'(count);
    assign rd_data = (rd_addr == LEVEL_OFS) ? WORD_W'(level) : '0;

    assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (count == '0 && !ovf_flag && !dsc_valid));
endmodule

// File: tb/lane_pack_fifo_tb.sv
`timescale 1ns/1ps
module lane_pack_fifo_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_clr = 1'b0;
    logic         wr_en = 1'b0;
    logic [11:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [11:0]  rd_addr = 12'h05C;
    logic [31:0]  rd_data;
    logic         ovf_flag, dsc_valid, dsc_last;
    logic         dsc_ready = 1'b0;
    logic [127:0] dsc_data;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lane_pack_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
        .dsc_data(dsc_data), .dsc_last(dsc_last)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] lane_addr(input int i);
        return 12'h178 + 12'(4 * i);
    endfunction

    function automatic logic [31:0] lane_of(input logic [127:0] w, input int i);
        return w[32*i +: 32];
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_word(input logic [127:0] w);
        for (int i = 0; i < 4; i++) wr(lane_addr(i), lane_of(w, i));
    endtask

    task automatic chk_level(input int exp, input string req);
        chk(rd_data == 32'(exp), req, 128'(rd_data), 128'(exp));
    endtask

    task automatic take(input logic [127:0] exp, input bit exp_last, input string req);
        for (int k = 0; k < 20 && !dsc_valid; k++) @(negedge clk);
        chk(dsc_valid == 1'b1, req, 128'(dsc_valid), 128'(1));
        chk(dsc_data == exp, req, dsc_data, exp);
        chk(dsc_last == exp_last, req, 128'(dsc_last), 128'(exp_last));
        dsc_ready = 1'b1;
        @(negedge clk);
        dsc_ready = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); soft_clr = 1'b1;
        @(negedge clk); soft_clr = 1'b0;
    endtask

    function automatic logic [127:0] mk(input int tag);
        logic [127:0] w;
        for (int i = 0; i < 4; i++) w[32*i +: 32] = {8'(tag & 8'h7F), 8'(i), 16'h5A3C};
        return w;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] w, e, hd, tl;
        logic [31:0]  fresh;
        int idx;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_level(0, "R1");
        chk(dsc_valid == 1'b0, "R1", 128'(dsc_valid), 128'(0));
        chk(ovf_flag == 1'b0, "R1", 128'(ovf_flag), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk_level(0, "R1");

        // R2 / R6: every lane order builds the same word, pushed only on the fourth write
        idx = 0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++) begin
                        if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                        w = mk(idx);
                        wr(lane_addr(a), lane_of(w, a));
                        wr(lane_addr(b), lane_of(w, b));
                        wr(lane_addr(c), lane_of(w, c));
                        chk_level(0, "R2");
                        chk(dsc_valid == 1'b0, "R2", 128'(dsc_valid), 128'(0));
                        wr(lane_addr(d), lane_of(w, d));
                        chk_level(1, "R2");
                        take(w, 1'b1, "R6");
                        chk_level(0, "R4");
                        idx++;
                    end

        // R3: rewritten lane keeps the later value and adds no lane
        w = mk(40);
        wr(lane_addr(0), 32'h1111_2222);
        wr(lane_addr(0), lane_of(w, 0));
        wr(lane_addr(1), lane_of(w, 1));
        wr(lane_addr(1), lane_of(w, 1));
        chk_level(0, "R3");
        wr(lane_addr(2), lane_of(w, 2));
        chk_level(0, "R3");
        wr(lane_addr(3), lane_of(w, 3));
        chk_level(1, "R3");
        take(w, 1'b1, "R3");

        // R10: stray and misaligned writes touch no lane
        w = mk(41);
        for (int i = 0; i < 3; i++) wr(lane_addr(i), lane_of(w, i));
        wr(12'h188, 32'hDEAD_BEEF);
        wr(12'h174, 32'hDEAD_BEEF);
        wr(12'h17A, 32'hDEAD_BEEF);
        wr(12'h05C, 32'hDEAD_BEEF);
        chk_level(0, "R10");
        wr(lane_addr(3), lane_of(w, 3));
        chk_level(1, "R10");
        take(w, 1'b1, "R10");

        // R4: other read addresses return zero
        put_word(mk(42));
        rd_addr = 12'h060; #1;
        chk(rd_data == 32'h0, "R4", 128'(rd_data), 128'(0));
        rd_addr = 12'h05C; #1;
        chk_level(1, "R4");
        take(mk(42), 1'b1, "R4");

        // R4 / R5: fill, overflow, retry with the missing lane only
        for (int k = 0; k < 8; k++) begin
            put_word(mk(50 + k));
            chk_level(k + 1, "R4");
        end
        e = mk(70);
        for (int i = 0; i < 3; i++) wr(lane_addr(i), lane_of(e, i));
        chk(ovf_flag == 1'b0, "R5", 128'(ovf_flag), 128'(0));
        wr(lane_addr(3), lane_of(e, 3));
        chk(ovf_flag == 1'b1, "R5", 128'(ovf_flag), 128'(1));
        chk_level(8, "R5");
        take(mk(50), 1'b1, "R5");
        chk_level(7, "R5");
        fresh = 32'h0BAD_F00D;
        wr(lane_addr(3), fresh);
        chk_level(8, "R5");
        for (int k = 1; k < 8; k++) take(mk(50 + k), 1'b1, "R5");
        e[127:96] = fresh;
        take(e, 1'b1, "R5");
        chk(ovf_flag == 1'b1, "R5", 128'(ovf_flag), 128'(1));
        chk_level(0, "R5");

        // R7 / R8: long descriptor withheld until complete, header first, hold while not ready
        hd = mk(80); hd[127] = 1'b1;
        tl = mk(81); tl[127] = 1'b1;
        put_word(hd);
        repeat (3) @(negedge clk);
        chk(dsc_valid == 1'b0, "R7", 128'(dsc_valid), 128'(0));
        chk_level(1, "R7");
        put_word(tl);
        chk(dsc_valid == 1'b1, "R7", 128'(dsc_valid), 128'(1));
        repeat (3) @(negedge clk);
        chk(dsc_valid == 1'b1, "R8", 128'(dsc_valid), 128'(1));
        chk(dsc_data == hd, "R8", dsc_data, hd);
        chk_level(2, "R8");
        take(hd, 1'b0, "R7");
        chk_level(1, "R7");
        take(tl, 1'b1, "R7");
        put_word(mk(82));
        take(mk(82), 1'b1, "R6");

        // R9: soft clear with data, partial mask and overflow pending
        for (int k = 0; k < 8; k++) put_word(mk(90 + k));
        for (int i = 0; i < 4; i++) wr(lane_addr(i), lane_of(mk(99), i));
        chk(ovf_flag == 1'b1, "R9", 128'(ovf_flag), 128'(1));
        pulse_clear();
        w = mk(100);
        wr(lane_addr(0), lane_of(w, 0));
        wr(lane_addr(1), lane_of(w, 1));
        pulse_clear();
        chk_level(0, "R9");
        chk(dsc_valid == 1'b0, "R9", 128'(dsc_valid), 128'(0));
        chk(ovf_flag == 1'b0, "R9", 128'(ovf_flag), 128'(0));
        wr(lane_addr(2), lane_of(w, 2));
        wr(lane_addr(3), lane_of(w, 3));
        chk_level(0, "R9");
        wr(lane_addr(0), lane_of(w, 0));
        wr(lane_addr(1), lane_of(w, 1));
        chk_level(1, "R9");
        take(w, 1'b1, "R9");

        summary();
        $finish;
    end
endmodule